// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Bus

This block is a target on a two-wire serial bus in the I2C style. Through it, a host reads and writes a small file of configuration registers. The block runs on a local system clock. It samples SCL and SDA through synchronisers and drives SDA only as an open-drain pull-down enable. It answers one 7-bit device address. That address comes either from a 2-bit select input or, if a register bit says so, from a field held in the register file.

A write carries three things in order: the device address, one byte that sets the register pointer, and any number of data bytes. The pointer steps up after every byte, whether written or read. To read, the host first sets the pointer with a write. It then issues a repeated START with the read bit set and clocks bytes out until it answers with a NACK.

Register 0 holds the configuration fields. Its lowest bit selects where every effective configuration output comes from: the live control-pin inputs or the register fields. A power-down input returns all registers to their defaults. The sleep bit leaves their contents untouched.

Top module: `cfg_i2c_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bits clocked without a preceding START are ignored. A STOP ends any transfer and leaves SDA released.
- R2: The pin-selected device address is 0x69, 0x6A, 0x6B or 0x6E for idSel 00, 01, 10 or 11. A matching address byte is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: An address byte that does not match gets no acknowledge (SDA stays released), and the transfer that follows changes no register.
- R4: In a write, the first byte after the address loads the register pointer. Each data byte after it is stored at the pointer and acknowledged, and the pointer then steps up by one.
- R5: In a read (address byte with bit 0 = 1), bytes are sent MSB first starting at the pointer, which steps up after each byte. Sending continues while the host acknowledges. After a host NACK, SDA stays released.
- R6: Register 0 resets to 0x00. Its bits are: bit 0 source select, bit 1 sleep, bits 3:2 filter mode, bit 4 rising-edge select, bit 5 high-swing select. Writes to bits 7:6 are ignored, and those bits read back as 0.
- R7: While register 0 bit 0 is 0, every effective output follows its control pin. While it is 1, every effective output follows its register 0 field, and cfgFromRegs is 1.
- R8: Register 1 resets to 0x68. When its bit 7 is 1, the device address is its bits 6:0 instead of the pin-selected address.
- R9: Register indices 2 and above hold nothing. Writes there are acknowledged but have no effect, and reads return 0x00.
- R10: Asserting pwrDown returns both registers to their reset values. Setting the sleep bit leaves all register contents in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDown | input | 1 | Synchronous power-down; returns registers and bus logic to defaults |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaOe | output | 1 | 1 pulls SDA low |
| idSel | input | 2 | Selects one of four device addresses |
| pinVodHi | input | 1 | Control pin: high output swing |
| pinRiseEdge | input | 1 | Control pin: rising-edge select |
| pinFiltMode | input | 2 | Control pin: filter mode (00 off, 01 on) |
| pinSleep | input | 1 | Control pin: sleep request |
| effVodHi | output | 1 | Effective high output swing |
| effRiseEdge | output | 1 | Effective rising-edge select |
| effFiltMode | output | 2 | Effective filter mode |
| effSleep | output | 1 | Effective sleep request |
| cfgFromRegs | output | 1 | 1 when the register fields drive the effective outputs |

## Verification
A wrong bus state shows up at SDA within one bit time. A missing acknowledge, or an acknowledge where none belongs, appears on the ninth pulse of the byte in question. A stuck pull-down makes the following STOP impossible to see. A pointer that fails to step up shows in the very next byte read back, because the values written to neighbouring registers differ. A broken field mapping or source select shows on the effective outputs a few clocks after the STOP, since the pins are always driven with a pattern opposite to the register contents.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK
  } busState_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rxKind_e;

  // strobes from bus control to the register datapath
  typedef struct packed {
    logic capture;   // shift in one received bit
    logic setPtr;    // received byte becomes the pointer
    logic writeReg;  // received byte stored at pointer, pointer steps
    logic loadTx;    // load byte at pointer for sending, pointer steps
    logic shiftTx;   // advance to the next outgoing bit
  } dpStrobe_t;

endpackage

// File: rtl/cfg_i2c_ctrl.sv
module cfg_i2c_ctrl
  import cfg_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrDown,
  input  logic      sclIn,
  input  logic      sdaIn,
  input  logic      addrHit,
  input  logic      rwBit,
  input  logic      txMsb,
  output dpStrobe_t strb,
  output logic      sdaSync,
  output logic      sdaOe
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclD, sdaD;
  logic sclRise, sclFall, startEv, stopEv;

  busState_e        state;
  rxKind_e          kind;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead;
  logic             masterAck;
  logic             byteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclD    <= sclS;
      sdaD    <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sdaSync = sdaS;
  assign sclRise = sclS & ~sclD;
  assign sclFall = ~sclS & sclD;
  assign startEv = sclS & sclD & sdaD & ~sdaS;
  assign stopEv  = sclS & sclD & ~sdaD & sdaS;

  assign byteDone = (state == ST_RECV) && sclFall && (bitCnt == LAST_BIT);

  always_comb begin
    strb          = '0;
    strb.capture  = (state == ST_RECV) && sclRise;
    strb.setPtr   = byteDone && (kind == K_PTR);
    strb.writeReg = byteDone && (kind == K_DATA);
    strb.loadTx   = ((state == ST_ACK) && sclFall && isRead) ||
                    ((state == ST_MACK) && sclFall && masterAck);
    strb.shiftTx  = (state == ST_SEND) && sclFall && (bitCnt != LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else if (pwrDown) begin
      state     <= ST_IDLE;
      kind      <= K_ADDR;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else if (startEv) begin
      state  <= ST_RECV;
      kind   <= K_ADDR;
      bitCnt <= '0;
      isRead <= 1'b0;
    end else if (stopEv) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_RECV: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            if (kind == K_ADDR) begin
              if (addrHit) begin
                state  <= ST_ACK;
                isRead <= rwBit;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state <= ST_ACK;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (isRead) begin
              state <= ST_SEND;
            end else begin
              state <= ST_RECV;
              kind  <= (kind == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_SEND: begin
          if (sclRise) bitCnt <= bitCnt + 1'b1;
          if (sclFall && (bitCnt == LAST_BIT)) begin
            state     <= ST_MACK;
            masterAck <= 1'b0;
          end
        end
        ST_MACK: begin
          if (sclRise) masterAck <= ~sdaS;
          if (sclFall) begin
            bitCnt <= '0;
            state  <= masterAck ? ST_SEND : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sdaOe = (state == ST_ACK) || ((state == ST_SEND) && !txMsb);

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN || pwrDown)
    stopEv |=> !sdaOe); // R1

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN || pwrDown)
    (!$stable(sdaOe) && !$past(pwrDown)) |-> !sclS); // R2

  AST_NACK_ON_MISS: assert property (@(posedge clk) disable iff (!rstN || pwrDown)
    (byteDone && (kind == K_ADDR) && !addrHit) |=> !sdaOe); // R3

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb)); // R5

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
  import cfg_i2c_pkg::*;
#(
  parameter int          NUM_REGS = 2,
  parameter int          PTR_W    = 8,
  parameter logic [7:0]  ID_RESET = 8'h68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDown,
  input  dpStrobe_t  strb,
  input  logic       sdaSync,
  input  logic [1:0] idSel,
  input  logic       pinVodHi,
  input  logic       pinRiseEdge,
  input  logic [1:0] pinFiltMode,
  input  logic       pinSleep,
  output logic       addrHit,
  output logic       rwBit,
  output logic       txMsb,
  output logic       effVodHi,
  output logic       effRiseEdge,
  output logic [1:0] effFiltMode,
  output logic       effSleep,
  output logic       cfgFromRegs
);

  localparam int CFG_IDX = 0;
  localparam int ID_IDX  = 1;

  function automatic logic [7:0] regMask(input int idx);
    case (idx)
      CFG_IDX: regMask = 8'h3F;
      ID_IDX:  regMask = 8'hFF;
      default: regMask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] regReset(input int idx);
    regReset = (idx == ID_IDX) ? ID_RESET : 8'h00;
  endfunction

  function automatic logic [6:0] pinAddr(input logic [1:0] sel);
    case (sel)
      2'b00:   pinAddr = 7'h69;
      2'b01:   pinAddr = 7'h6A;
      2'b10:   pinAddr = 7'h6B;
      default: pinAddr = 7'h6E;
    endcase
  endfunction

  logic [NUM_REGS-1:0][7:0] regFile;
  logic [PTR_W-1:0]         ptrQ;
  logic [7:0]               shiftQ;
  logic [7:0]               rdByte;
  logic [6:0]               devAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= regReset(i);
    end else if (pwrDown) begin
      for (int i = 0; i < NUM_REGS; i++) regFile[i] <= regReset(i);
    end else if (strb.writeReg) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (ptrQ == PTR_W'(i)) regFile[i] <= shiftQ & regMask(i);
    end
  end

  always_comb begin
    rdByte = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptrQ == PTR_W'(i)) rdByte = regFile[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      shiftQ <= '0;
    end else if (pwrDown) begin
      ptrQ   <= '0;
      shiftQ <= '0;
    end else begin
      if (strb.capture)  shiftQ <= {shiftQ[6:0], sdaSync};
      if (strb.loadTx)   shiftQ <= rdByte;
      if (strb.shiftTx)  shiftQ <= {shiftQ[6:0], 1'b0};
      if (strb.setPtr)   ptrQ   <= PTR_W'(shiftQ);
      if (strb.writeReg || strb.loadTx) ptrQ <= ptrQ + PTR_W'(1);
    end
  end

  assign devAddr = regFile[ID_IDX][7] ? regFile[ID_IDX][6:0] : pinAddr(idSel);
  assign addrHit = (shiftQ[7:1] == devAddr);
  assign rwBit   = shiftQ[0];
  assign txMsb   = shiftQ[7];

  assign cfgFromRegs = regFile[CFG_IDX][0];
  assign effSleep    = cfgFromRegs ? regFile[CFG_IDX][1]   : pinSleep;
  assign effFiltMode = cfgFromRegs ? regFile[CFG_IDX][3:2] : pinFiltMode;
  assign effRiseEdge = cfgFromRegs ? regFile[CFG_IDX][4]   : pinRiseEdge;
  assign effVodHi    = cfgFromRegs ? regFile[CFG_IDX][5]   : pinVodHi;

  AST_PD_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |=> (regFile[CFG_IDX] == 8'h00 && regFile[ID_IDX] == ID_RESET)); // R10

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN || pwrDown)
    (strb.writeReg || strb.loadTx) |=> (ptrQ == $past(ptrQ) + PTR_W'(1))); // R4

  AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeReg |=> (regFile[CFG_IDX][7:6] == 2'b00)); // R6

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         NUM_REGS    = 2,
  parameter int         PTR_W       = 8,
  parameter logic [7:0] ID_RESET    = 8'h68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDown,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic [1:0] idSel,
  input  logic       pinVodHi,
  input  logic       pinRiseEdge,
  input  logic [1:0] pinFiltMode,
  input  logic       pinSleep,
  output logic       effVodHi,
  output logic       effRiseEdge,
  output logic [1:0] effFiltMode,
  output logic       effSleep,
  output logic       cfgFromRegs
);

  dpStrobe_t strb;
  logic      sdaSync, addrHit, rwBit, txMsb;

  cfg_i2c_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .addrHit(addrHit), .rwBit(rwBit), .txMsb(txMsb),
    .strb(strb), .sdaSync(sdaSync), .sdaOe(sdaOe)
  );

  cfg_i2c_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .ID_RESET(ID_RESET)) regs (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown),
    .strb(strb), .sdaSync(sdaSync), .idSel(idSel),
    .pinVodHi(pinVodHi), .pinRiseEdge(pinRiseEdge),
    .pinFiltMode(pinFiltMode), .pinSleep(pinSleep),
    .addrHit(addrHit), .rwBit(rwBit), .txMsb(txMsb),
    .effVodHi(effVodHi), .effRiseEdge(effRiseEdge),
    .effFiltMode(effFiltMode), .effSleep(effSleep),
    .cfgFromRegs(cfgFromRegs)
  );

endmodule

// File: tb/cfg_i2c_target_test.sv
module cfg_i2c_target_test;

  localparam int Q = 10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0, pwrDown = 1'b0;
  logic       scl = 1'b1, mDrvLow = 1'b0;
  logic [1:0] idSel = 2'b00;
  logic       pinVodHi = 1'b0, pinRiseEdge = 1'b0, pinSleep = 1'b0;
  logic [1:0] pinFiltMode = 2'b00;
  logic       sdaOe, effVodHi, effRiseEdge, effSleep, cfgFromRegs;
  logic [1:0] effFiltMode;
  wire        sdaLine = ~(mDrvLow | sdaOe);

  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic [7:0] wrBuf [4];
  logic [7:0] rdBuf [4];

  cfg_i2c_target uut (
    .clk(clk), .rstN(rstN), .pwrDown(pwrDown),
    .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe), .idSel(idSel),
    .pinVodHi(pinVodHi), .pinRiseEdge(pinRiseEdge),
    .pinFiltMode(pinFiltMode), .pinSleep(pinSleep),
    .effVodHi(effVodHi), .effRiseEdge(effRiseEdge),
    .effFiltMode(effFiltMode), .effSleep(effSleep),
    .cfgFromRegs(cfgFromRegs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mDrvLow = 1'b0; q(); mDrvLow = 1'b1; q(); scl = 1'b0; q();
  endtask

  task automatic busRestart();
    mDrvLow = 1'b0; q(); scl = 1'b1; q(); mDrvLow = 1'b1; q(); scl = 1'b0; q();
  endtask

  task automatic busStop();
    mDrvLow = 1'b1; q(); scl = 1'b1; q(); mDrvLow = 1'b0; q();
  endtask

  task automatic putBit(input logic b);
    mDrvLow = ~b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
  endtask

  task automatic getBit(output logic b);
    mDrvLow = 1'b0; q(); scl = 1'b1; q(); b = sdaLine; q(); scl = 1'b0; q();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(x);
    ack = ~x;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      getBit(x);
      b[i] = x;
    end
    putBit(~mAck);
    mDrvLow = 1'b0;
  endtask

  task automatic wrRegs(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                        output logic allAck);
    logic a;
    busStart();
    sendByte({dev, 1'b0}, a);
    allAck = a;
    if (a) begin
      sendByte(ptr, a);
      allAck &= a;
      for (int i = 0; i < n; i++) begin
        sendByte(wrBuf[i], a);
        allAck &= a;
      end
    end
    busStop();
    q();
  endtask

  task automatic rdRegs(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                        output logic ok, output logic released);
    logic a;
    busStart();
    sendByte({dev, 1'b0}, a);
    ok = a;
    sendByte(ptr, a);
    ok &= a;
    busRestart();
    sendByte({dev, 1'b1}, a);
    ok &= a;
    for (int i = 0; i < n; i++) recvByte(i < n - 1, rdBuf[i]);
    q();
    released = sdaLine;
    busStop();
    q();
  endtask

  task automatic tReset();
    logic ok, rel;
    pinVodHi = 1'b1; pinRiseEdge = 1'b0; pinFiltMode = 2'b01; pinSleep = 1'b1;
    q();
    chk("R7 reset vod follows pin", effVodHi, 1'b1);
    chk("R7 reset edge follows pin", effRiseEdge, 1'b0);
    chk("R7 reset mode follows pin", effFiltMode, 2'b01);
    chk("R7 reset sleep follows pin", effSleep, 1'b1);
    chk("R6 reset source bit", cfgFromRegs, 1'b0);
    chk("R1 reset sda released", sdaOe, 1'b0);
    rdRegs(7'h69, 8'h00, 2, ok, rel);
    chk("R6 reg0 reset", rdBuf[0], 8'h00);
    chk("R8 reg1 reset", rdBuf[1], 8'h68);
  endtask

  task automatic tAddrSelect();
    logic [6:0] addrs [4] = '{7'h69, 7'h6A, 7'h6B, 7'h6E};
    logic a;
    for (int id = 0; id < 4; id++) begin
      idSel = 2'(id);
      q();
      busStart(); sendByte({addrs[id], 1'b0}, a); busStop(); q();
      chk($sformatf("R2 ack for idSel %0d", id), a, 1'b1);
    end
    idSel = 2'b11;
    busStart(); sendByte({7'h69, 1'b0}, a); busStop(); q();
    chk("R3 nack foreign address", a, 1'b0);
    idSel = 2'b00;
    q();
  endtask

  task automatic tWriteRead();
    logic ok, rel;
    wrBuf[0] = 8'h3D; wrBuf[1] = 8'h55;
    wrRegs(7'h69, 8'h00, 2, ok);
    chk("R4 write acks", ok, 1'b1);
    rdRegs(7'h69, 8'h00, 2, ok, rel);
    chk("R5 read acks", ok, 1'b1);
    chk("R4 reg0 stored", rdBuf[0], 8'h3D);
    chk("R5 auto-increment reg1", rdBuf[1], 8'h55);
    chk("R5 sda released after nack", rel, 1'b1);
  endtask

  task automatic tMux();
    logic ok;
    pinVodHi = 1'b0; pinRiseEdge = 1'b0; pinFiltMode = 2'b00; pinSleep = 1'b1;
    q();
    chk("R7 vod from reg", effVodHi, 1'b1);
    chk("R7 edge from reg", effRiseEdge, 1'b1);
    chk("R7 mode from reg", effFiltMode, 2'b11);
    chk("R7 sleep from reg", effSleep, 1'b0);
    chk("R7 source flag", cfgFromRegs, 1'b1);
    wrBuf[0] = 8'h3C;
    wrRegs(7'h69, 8'h00, 1, ok);
    chk("R7 back to pins vod", effVodHi, 1'b0);
    chk("R7 back to pins mode", effFiltMode, 2'b00);
    chk("R7 back to pins sleep", effSleep, 1'b1);
    chk("R7 source flag clear", cfgFromRegs, 1'b0);
  endtask

  task automatic tReserved();
    logic ok, rel;
    wrBuf[0] = 8'hFF;
    wrRegs(7'h69, 8'h00, 1, ok);
    rdRegs(7'h69, 8'h00, 1, ok, rel);
    chk("R6 reserved bits read zero", rdBuf[0], 8'h3F);
    wrBuf[0] = 8'hAA;
    wrRegs(7'h69, 8'h02, 1, ok);
    chk("R9 unmapped write acked", ok, 1'b1);
    rdRegs(7'h69, 8'h01, 2, ok, rel);
    chk("R9 reg1 untouched", rdBuf[0], 8'h55);
    chk("R9 unmapped reads zero", rdBuf[1], 8'h00);
  endtask

  task automatic tWrongAddr();
    logic ok, rel;
    wrBuf[0] = 8'h12;
    wrRegs(7'h6A, 8'h00, 1, ok);
    chk("R3 foreign write nacked", ok, 1'b0);
    rdRegs(7'h69, 8'h00, 1, ok, rel);
    chk("R3 reg0 unchanged", rdBuf[0], 8'h3F);
  endtask

  task automatic tNoStart();
    logic x, a;
    scl = 1'b0; q();
    for (int i = 7; i >= 0; i--) putBit(logic'(8'hD2 >> i));
    getBit(x);
    chk("R1 no ack without start", x, 1'b1);
    mDrvLow = 1'b0; q(); scl = 1'b1; q();
    busStart(); sendByte(8'hD2, a); busStop(); q();
    chk("R1 ack before stop", a, 1'b1);
    chk("R1 released after stop", sdaLine, 1'b1);
  endtask

  task automatic tAddrReg();
    logic ok, a, rel;
    wrBuf[0] = 8'hA1;
    wrRegs(7'h69, 8'h01, 1, ok);
    busStart(); sendByte({7'h69, 1'b0}, a); busStop(); q();
    chk("R8 pin address now ignored", a, 1'b0);
    rdRegs(7'h21, 8'h01, 1, ok, rel);
    chk("R8 register address acked", ok, 1'b1);
    chk("R8 reg1 readback", rdBuf[0], 8'hA1);
    wrBuf[0] = 8'h55;
    wrRegs(7'h21, 8'h01, 1, ok);
  endtask

  task automatic tSleepPd();
    logic ok, rel;
    wrBuf[0] = 8'h03;
    wrRegs(7'h69, 8'h00, 1, ok);
    chk("R10 sleep active", effSleep, 1'b1);
    rdRegs(7'h69, 8'h00, 2, ok, rel);
    chk("R10 reg0 kept in sleep", rdBuf[0], 8'h03);
    chk("R10 reg1 kept in sleep", rdBuf[1], 8'h55);
    pinSleep = 1'b0;
    pwrDown = 1'b1; q(); pwrDown = 1'b0; q();
    chk("R10 power-down source clear", cfgFromRegs, 1'b0);
    chk("R10 power-down sleep from pin", effSleep, 1'b0);
    rdRegs(7'h69, 8'h00, 2, ok, rel);
    chk("R10 reg0 default", rdBuf[0], 8'h00);
    chk("R10 reg1 default", rdBuf[1], 8'h68);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tAddrSelect();
    tWriteRead();
    tMux();
    tReserved();
    tWrongAddr();
    tNoStart();
    tAddrReg();
    tSleepPd();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule